// File: doc/BRIEF.md
# Dual-Slope Conversion Result Capture

This block is the result path of a dual-slope converter's digital section. An external sequencer walks each conversion through auto-zero, input integration and de-integration, and signals the current phase on three level inputs. During de-integration the block counts clock cycles until the comparator reports a zero crossing. When de-integration ends, it transfers the count, a sign bit and an over-range bit into output holding registers.

A STATUS flag brackets the update. It rises when a new input integration begins. It falls half a clock period after the fresh result has been stored, so a reader that sees STATUS low knows the held word will not move. The output word is a level-held result with no valid/ready handshake and no back-pressure. A consumer reads it at any time while STATUS is low, and nothing it does can stall the converter. Results that are not read are simply replaced by the next conversion.

Top module: `intadc_result_capture`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after its release, `res_count`, `res_pol`, `res_ovr` and `status` are all 0 until a conversion completes.
- R2: On the first rising clock edge at which `int_phase` is high after being low, `status` goes high and stays high until R8 clears it.
- R3: The counter is cleared while `az_phase` is high and at the start of integration. The stored count equals the number of rising edges with `deint_phase` high that come before the first edge at which `zero_cross` is high.
- R4: Counting stops at the first zero crossing of a de-integration. A later drop of `zero_cross` within the same phase does not restart it.
- R5: If de-integration would take the count beyond all ones (2^CNT_W-1), the count holds at all ones and the over-range bit `res_ovr` is stored as 1. A count that reaches exactly all ones stores `res_ovr` as 0.
- R6: `res_pol` stores the value of `pol_in` sampled on the last rising edge at which `int_phase` was high.
- R7: The result registers load on the first rising edge at which `deint_phase` is low after being high, provided `status` is high.
- R8: After that load edge, `status` stays high until the following falling clock edge and is low from then on.
- R9: `res_count`, `res_pol` and `res_ovr` never change while `status` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; counting and loading on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| az_phase | input | 1 | Sequencer: auto-zero phase active |
| int_phase | input | 1 | Sequencer: input-integrate phase active |
| deint_phase | input | 1 | Sequencer: de-integrate phase active |
| zero_cross | input | 1 | Comparator: integrator has crossed zero |
| pol_in | input | 1 | Comparator sign during integration |
| res_count | output | CNT_W | Held de-integration count |
| res_pol | output | 1 | Held sign bit |
| res_ovr | output | 1 | Held over-range bit |
| status | output | 1 | High while a conversion is in flight; data stable while low |

## Verification
The assertions check four things on every cycle. Status rises one edge after integration starts. The held word is frozen whenever status is low. An over-range word always carries an all-ones count. Any change of the held word is seen at a falling edge while status is still high, which proves the half-cycle fall. The count value itself, saturation exactly at the all-ones boundary, and stopping at the first crossing when `zero_cross` pulses only once can be shown only by the bench. It sends directed and random conversions through the block and compares each stored word with a computed expectation.

// File: rtl/intcap_pkg.sv
package intcap_pkg;
  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,
    CNT_RUN  = 2'd1,
    CNT_DONE = 2'd2
  } cnt_state_e;

  // Saturating increment: returns the next count and whether it overflowed.
  function automatic logic [32:0] sat_step(input logic [31:0] cur, input logic [31:0] maxv);
    logic [32:0] r;
    if (cur >= maxv) r = {1'b1, maxv};
    else             r = {1'b0, cur + 32'd1};
    return r;
  endfunction
endpackage

// File: rtl/intcap_phase_edges.sv
module intcap_phase_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic int_phase,
  input  logic deint_phase,
  output logic int_start,
  output logic deint_end
);
  logic int_d;
  logic deint_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_d   <= 1'b0;
      deint_d <= 1'b0;
    end else begin
      int_d   <= int_phase;
      deint_d <= deint_phase;
    end
  end

  assign int_start = int_phase & ~int_d;
  assign deint_end = deint_d & ~deint_phase;
endmodule

// File: rtl/intcap_counter.sv
module intcap_counter
  import intcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             deint_phase,
  input  logic             zero_cross,
  output logic [CNT_W-1:0] cnt,
  output logic             ovr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cnt_state_e st_q;
  logic       at_max;

  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ovr  <= 1'b0;
      st_q <= CNT_IDLE;
    end else if (clr) begin
      cnt  <= '0;
      ovr  <= 1'b0;
      st_q <= CNT_IDLE;
    end else if (deint_phase && st_q != CNT_DONE) begin
      if (zero_cross) begin
        st_q <= CNT_DONE;
      end else if (at_max) begin
        ovr  <= 1'b1;
        st_q <= CNT_DONE;
      end else begin
        cnt  <= cnt + 1'b1;
        st_q <= CNT_RUN;
      end
    end
  end
endmodule

// File: rtl/intcap_result_latch.sv
module intcap_result_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_phase,
  input  logic             pol_in,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovr,
  output logic [CNT_W-1:0] res_count,
  output logic             res_pol,
  output logic             res_ovr
);
  logic pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pol_q <= 1'b0;
    else if (int_phase) pol_q <= pol_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_count <= '0;
      res_pol   <= 1'b0;
      res_ovr   <= 1'b0;
    end else if (load) begin
      res_count <= cnt;
      res_pol   <= pol_q;
      res_ovr   <= ovr;
    end
  end
endmodule

// File: rtl/intcap_status.sv
module intcap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic int_start,
  input  logic load,
  output logic busy,
  output logic status
);
  logic hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (int_start) busy <= 1'b1;
    else if (load)      busy <= 1'b0;
  end

  // Falling-edge copy keeps the flag up for the half period after a load.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_n <= 1'b0;
    else        hold_n <= busy;
  end

  assign status = busy | hold_n;
endmodule

// File: rtl/intadc_result_capture.sv
module intadc_result_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             az_phase,
  input  logic             int_phase,
  input  logic             deint_phase,
  input  logic             zero_cross,
  input  logic             pol_in,
  output logic [CNT_W-1:0] res_count,
  output logic             res_pol,
  output logic             res_ovr,
  output logic             status
);
  logic             int_start;
  logic             deint_end;
  logic             busy;
  logic             load;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             ovr;

  assign clr  = az_phase | int_start;
  assign load = deint_end & busy;

  intcap_phase_edges u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_phase  (int_phase),
    .deint_phase(deint_phase),
    .int_start  (int_start),
    .deint_end  (deint_end)
  );

  intcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .deint_phase(deint_phase),
    .zero_cross (zero_cross),
    .cnt        (cnt),
    .ovr        (ovr)
  );

  intcap_result_latch #(.CNT_W(CNT_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_phase(int_phase),
    .pol_in   (pol_in),
    .load     (load),
    .cnt      (cnt),
    .ovr      (ovr),
    .res_count(res_count),
    .res_pol  (res_pol),
    .res_ovr  (res_ovr)
  );

  intcap_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_start(int_start),
    .load     (load),
    .busy     (busy),
    .status   (status)
  );
endmodule

// File: rtl/intcap_checker.sv
module intcap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_phase,
  input logic [CNT_W-1:0] res_count,
  input logic             res_pol,
  input logic             res_ovr,
  input logic             status
);
  logic [CNT_W+1:0] word;
  assign word = {res_pol, res_ovr, res_count};

  assert_status_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_phase) |=> status);

  assert_saturated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr |-> (&res_count));

  assert_frozen_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status |=> $stable(word));

  assert_half_cycle_fall_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(word) |-> status);
endmodule

bind intadc_result_capture intcap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .int_phase(int_phase),
  .res_count(res_count),
  .res_pol  (res_pol),
  .res_ovr  (res_ovr),
  .status   (status)
);

// File: tb/intadc_result_capture_tb.sv
module intadc_result_capture_tb;
  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int NONE  = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             az_phase = 1'b0, int_phase = 1'b0, deint_phase = 1'b0;
  logic             zero_cross = 1'b0, pol_in = 1'b0;
  logic [CNT_W-1:0] res_count;
  logic             res_pol, res_ovr, status;

  int n_chk = 0;
  int n_bad = 0;
  logic [CNT_W+1:0] held = '0;

  always #5 clk = ~clk;

  intadc_result_capture #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .az_phase(az_phase), .int_phase(int_phase),
    .deint_phase(deint_phase), .zero_cross(zero_cross), .pol_in(pol_in),
    .res_count(res_count), .res_pol(res_pol), .res_ovr(res_ovr), .status(status)
  );

  function automatic logic [CNT_W+1:0] exp_word(input logic p, input int d, input int k);
    int eff;
    eff = (k < d) ? k : d;
    if (eff > MAXV) return {p, 1'b1, CNT_W'(MAXV)};
    return {p, 1'b0, CNT_W'(eff)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic conv(input int az_n, input int in_n, input int d, input int k, input bit pulse);
    logic lastpol;
    logic [CNT_W+1:0] e;
    lastpol = 1'b0;
    for (int i = 0; i < az_n; i++) begin
      @(negedge clk); az_phase = 1'b1;
      @(posedge clk); #2;
    end
    for (int i = 0; i < in_n; i++) begin
      @(negedge clk); az_phase = 1'b0; int_phase = 1'b1;
      pol_in = 1'($urandom); lastpol = pol_in;
      @(posedge clk); #2;
      if (i == 0) begin
        chk("R2 status rises at integrate", {31'b0, status}, 1);
        chk("R9 word held into integrate", {{(30-CNT_W){1'b0}}, res_pol, res_ovr, res_count},
            {{(30-CNT_W){1'b0}}, held});
      end
    end
    for (int j = 0; j < d; j++) begin
      @(negedge clk); az_phase = 1'b0; int_phase = 1'b0; deint_phase = 1'b1;
      zero_cross = pulse ? (j == k) : (j >= k);
      @(posedge clk); #2;
    end
    @(negedge clk); deint_phase = 1'b0; zero_cross = 1'b0;
    @(posedge clk); #2;
    e = exp_word(lastpol, d, k);
    chk("R3/R4 count", {{(32-CNT_W){1'b0}}, res_count}, {{(32-CNT_W){1'b0}}, e[CNT_W-1:0]});
    chk("R5 over-range", {31'b0, res_ovr}, {31'b0, e[CNT_W]});
    chk("R6 polarity", {31'b0, res_pol}, {31'b0, e[CNT_W+1]});
    chk("R8 status high after load edge", {31'b0, status}, 1);
    @(negedge clk); #2;
    chk("R8 status low after falling edge", {31'b0, status}, 0);
    held = e;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); zero_cross = 1'($urandom); pol_in = 1'($urandom);
      @(posedge clk); #2;
    end
    chk("R9/R7 word stable when idle", {{(30-CNT_W){1'b0}}, res_pol, res_ovr, res_count},
        {{(30-CNT_W){1'b0}}, held});
    zero_cross = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DC5));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 status in reset", {31'b0, status}, 0);
    chk("R1 word in reset", {{(30-CNT_W){1'b0}}, res_pol, res_ovr, res_count}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 status after reset", {31'b0, status}, 0);
    chk("R7 no load without conversion", {{(30-CNT_W){1'b0}}, res_pol, res_ovr, res_count}, 0);

    conv(2, 3, 5, 0, 1'b0);          // immediate crossing: count 0
    conv(1, 2, 10, 3, 1'b1);         // single-cycle crossing pulse
    conv(1, 4, MAXV, NONE, 1'b0);    // exactly all ones, no over-range
    conv(3, 1, MAXV + 1, NONE, 1'b0);// one beyond: over-range
    conv(1, 2, 400, 300, 1'b0);      // crossing long after saturation
    conv(2, 2, MAXV + 5, MAXV, 1'b1);// crossing at all ones
    for (int r = 0; r < 25; r++) begin
      int d;
      d = 1 + int'($urandom % 300);
      conv(1 + int'($urandom % 3), 1 + int'($urandom % 5), d,
           int'($urandom % (d + 40)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule